// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block is a cycle-based model of how a byte-wide parallel flash answers host reads while an internal program or erase runs. A one-cycle start pulse launches an operation: byte program, sector erase or chip erase. The pulse carries the target address, the byte to store, a protected-sector flag and a test-only flag that forces the timeout path. Each host read strobe made while the operation runs returns a status word. Bit 7 is a polling bit, bit 6 inverts on every read, and bit 5 flags that the pulse-count limit was exceeded.

When the operation ends, the block updates its small internal array. Protected operations leave the array untouched and only imitate activity for a fixed window. The first read after the end is a completion read: bit 7 already carries true array data, while bits 6 to 0 still carry status. From the next read on, the block is back in read mode and returns the stored bytes.

The command-cycle decoder is outside the block. Durations in microseconds are replaced by cycle-count parameters.

Top module: `flash_status_responder`

## Requirements
- R1: After reset, and whenever no operation is active, a read returns the array byte at `rd_addr_i`. After reset, byte i of the array holds (i*29 + 7) mod 256.
- R2: A start pulse taken with `busy_o` low raises `busy_o` on the next cycle. The op codes are 00 program, 01 sector erase and 10 chip erase. Code 11 is ignored. A start pulse received while `busy_o` is high has no effect on the running operation. `busy_o` stays high until the block is back in read mode.
- R3: During a byte program, bit 7 of each status read is the inverse of bit 7 of the byte being written. During a sector erase or chip erase it reads 0.
- R4: During an operation, bit 6 inverts on every read strobe, whatever the address. The first read after a start returns 0 in bit 6.
- R5: During an operation, bits 4 to 0 of a status read are 0. Bit 5 is 0 unless the timeout limit has been passed.
- R6: An unprotected operation runs for `PROG_CYC`, `SECT_CYC` or `CHIP_CYC` cycles. A program then stores the byte at the target address. A sector erase sets to FFh every byte whose top `SECT_W` address bits match the target. A chip erase sets every byte to FFh.
- R7: The first read after the run ends returns bit 7 from the array byte at the read address, bit 6 as the toggle, and bits 5 to 0 as 0. After that read, `busy_o` falls.
- R8: A program to a protected sector toggles status for `PPROG_CYC` cycles, then completes as in R7 with the array unchanged.
- R9: An erase with the protected flag set toggles status for `PERASE_CYC` cycles, then completes as in R7 with the array unchanged.
- R10: With `force_timeout_i` set at start, the block reports bit 5 = 0 for `PULSE_LIMIT` cycles. It then reports bit 5 = 1 for `FAIL_HOLD` cycles, with bits 7 and 6 behaving as in R3 and R4. It then returns straight to read mode with the array unchanged.
- R11: A read result appears on `rd_data_o` after the clock edge that samples `rd_i`. It holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle operation launch |
| op_i | input | 2 | Operation code (00 program, 01 sector erase, 10 chip erase) |
| addr_i | input | AW | Target address of the operation |
| data_i | input | 8 | Byte to program |
| prot_i | input | 1 | Target sector(s) protected |
| force_timeout_i | input | 1 | Test-only: make the operation exceed the pulse limit |
| rd_i | input | 1 | Host read strobe |
| rd_addr_i | input | AW | Host read address |
| rd_data_o | output | 8 | Read result (array data or status word) |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench builds the block with short windows: program 6, sector erase 14, chip erase 20, protected program 9, protected erase 25, pulse limit 32 and failure hold 10 cycles. It uses a 64-byte array split into four sectors. With these values, random read gaps of up to three cycles land in every phase of every operation, including the first and last cycle of each window and the completion read. Back-to-back reads pin the exact cycle of each phase boundary, and a start pulse injected mid-operation exercises the busy lockout.

// File: rtl/fsr_pkg.sv
// Package: shared types and helpers for the flash status responder.
// Assumes: byte-wide array; op codes fixed by the host-side decoder.
package fsr_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_NONE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_LAST = 2'b10,
        ST_FAIL = 2'b11
    } st_e;

    // Power-on content of array byte idx.
    function automatic logic [7:0] init_byte(input int unsigned idx);
        int unsigned v;
        v = (idx * 29 + 7) % 256;
        return v[7:0];
    endfunction

endpackage

// File: rtl/fsr_sequencer.sv
// Module: fsr_sequencer
// Tracks the phase of an embedded operation (idle, running, completion read,
// timeout hold) and counts its duration in cycles.
// Assumes: PULSE_LIMIT exceeds every normal and protected run length.
module fsr_sequencer
    import fsr_pkg::*;
#(
    parameter int PROG_CYC    = 12,
    parameter int SECT_CYC    = 40,
    parameter int CHIP_CYC    = 60,
    parameter int PPROG_CYC   = 20,
    parameter int PERASE_CYC  = 80,
    parameter int PULSE_LIMIT = 100,
    parameter int FAIL_HOLD   = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  op_e  op_i,
    input  logic prot_i,
    input  logic force_i,
    input  logic rd_i,
    output st_e  st_o,
    output op_e  op_q_o,
    output logic launch_o,
    output logic commit_o,
    output logic busy_o
);
    localparam int MAXV = PULSE_LIMIT + FAIL_HOLD;
    localparam int CW   = $clog2(MAXV + 1);

    st_e           st;
    op_e           op_q;
    logic          prot_q;
    logic          force_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] run_len;
    logic          run_end;

    // Pick the run length from the latched operation and flags.
    always_comb begin
        if (force_q)
            run_len = CW'(PULSE_LIMIT);
        else if (prot_q)
            run_len = (op_q == OP_PROG) ? CW'(PPROG_CYC) : CW'(PERASE_CYC);
        else if (op_q == OP_PROG)
            run_len = CW'(PROG_CYC);
        else if (op_q == OP_SECT)
            run_len = CW'(SECT_CYC);
        else
            run_len = CW'(CHIP_CYC);
    end

    assign launch_o = start_i && (st == ST_IDLE) && (op_i != OP_NONE);
    assign run_end  = (st == ST_RUN) && (cnt == run_len - CW'(1));
    assign commit_o = run_end && !force_q && !prot_q;
    assign busy_o   = (st != ST_IDLE);
    assign st_o     = st;
    assign op_q_o   = op_q;

    // Phase register and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            op_q    <= OP_PROG;
            prot_q  <= 1'b0;
            force_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (launch_o) begin
                        st      <= ST_RUN;
                        cnt     <= '0;
                        op_q    <= op_i;
                        prot_q  <= prot_i;
                        force_q <= force_i;
                    end
                end
                ST_RUN: begin
                    if (run_end) begin
                        st  <= force_q ? ST_FAIL : ST_LAST;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_FAIL: begin
                    if (cnt == CW'(FAIL_HOLD - 1)) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    if (rd_i) st <= ST_IDLE;
                end
            endcase
        end
    end

    // An accepted start makes the block busy on the next cycle.
    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i != OP_NONE) |=> busy_o);

    // A start while busy leaves the latched operation alone.
    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(op_q));

    // A commit always leads into the completion-read phase.
    assert_commit_to_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (st == ST_LAST && busy_o));

    // A code-11 start in idle never launches anything.
    assert_bad_op_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (!start_i || op_i == OP_NONE)) |=> !busy_o);

endmodule

// File: rtl/fsr_array.sv
// Module: fsr_array
// Small byte array with power-on pattern; applies the program or erase
// of a finished unprotected operation in one cycle.
// Assumes: sector index is the top SECT_W address bits.
module fsr_array
    import fsr_pkg::*;
#(
    parameter int AW     = 6,
    parameter int SECT_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    input  logic          commit_i,
    input  op_e           op_q_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_byte_o,
    output logic          prog_msb_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] tgt_q;
    logic [7:0]    dat_q;

    // Latch target address and byte on a launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            dat_q <= '0;
        end else if (launch_i) begin
            tgt_q <= addr_i;
            dat_q <= data_i;
        end
    end

    // Array storage: power-on pattern, then program or erase on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
        end else if (commit_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                logic [AW-1:0] ia;
                ia = AW'(i);
                if (op_q_i == OP_CHIP)
                    mem[i] <= 8'hFF;
                else if (op_q_i == OP_SECT && ia[AW-1 -: SECT_W] == tgt_q[AW-1 -: SECT_W])
                    mem[i] <= 8'hFF;
                else if (op_q_i == OP_PROG && ia == tgt_q)
                    mem[i] <= dat_q;
            end
        end
    end

    assign rd_byte_o  = mem[rd_addr_i];
    assign prog_msb_o = dat_q[7];

    // A committed program leaves the latched byte at the target.
    assert_prog_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && op_q_i == OP_PROG) |=> (mem[tgt_q] == dat_q));

    // A committed chip erase clears both ends of the array.
    assert_chip_erased_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && op_q_i == OP_CHIP) |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));

    // Without a commit the array never changes.
    assert_array_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(mem[rd_addr_i]) || $changed(rd_addr_i));

endmodule

// File: rtl/fsr_status.sv
// Module: fsr_status
// Builds the word returned by each read strobe: array data in read mode,
// polling/toggle/timeout status during an operation, and the mixed
// completion word on the first read after the run ends.
// Assumes: phase and latched operation come from fsr_sequencer.
module fsr_status
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  st_e        st_i,
    input  op_e        op_q_i,
    input  logic       prog_msb_i,
    input  logic       launch_i,
    input  logic       rd_i,
    input  logic [7:0] arr_byte_i,
    output logic [7:0] rd_data_o
);
    logic       tog;
    logic       poll;
    logic [7:0] word;

    assign poll = (op_q_i == OP_PROG) ? ~prog_msb_i : 1'b0;

    // Select the word for the current phase.
    always_comb begin
        case (st_i)
            ST_RUN:  word = {poll, tog, 1'b0, 5'b0};
            ST_FAIL: word = {poll, tog, 1'b1, 5'b0};
            ST_LAST: word = {arr_byte_i[7], tog, 6'b0};
            default: word = arr_byte_i;
        endcase
    end

    // Toggle bit: cleared on launch, inverted by every busy read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (launch_i)
            tog <= 1'b0;
        else if (rd_i && st_i != ST_IDLE)
            tog <= ~tog;
    end

    // Read data register: updated only by a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_o <= 8'h00;
        else if (rd_i)
            rd_data_o <= word;
    end

    // Running reads carry zeros in bits 5..0.
    assert_run_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st_i == ST_RUN) |=> (rd_data_o[5:0] == 6'b0));

    // Erase polling reads 0 while running.
    assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st_i == ST_RUN && op_q_i != OP_PROG) |=> !rd_data_o[7]);

    // Timeout hold reads show bit 5 set.
    assert_fail_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st_i == ST_FAIL) |=> rd_data_o[5]);

    // Output holds between read strobes.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o));

    // Two back-to-back running reads give opposite bit 6.
    assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st_i == ST_RUN && $past(rd_i && st_i == ST_RUN) && !$past(launch_i))
        |=> (rd_data_o[6] != $past(rd_data_o[6])));

endmodule

// File: rtl/flash_status_responder.sv
// Module: flash_status_responder (top)
// Synchronous model of flash status reads during embedded program and
// erase operations. Ties the sequencer, the array and the status word
// builder together.
// Assumes: start_i is a single-cycle pulse from an external command decoder.
module flash_status_responder
    import fsr_pkg::*;
#(
    parameter int AW          = 6,
    parameter int SECT_W      = 2,
    parameter int PROG_CYC    = 12,
    parameter int SECT_CYC    = 40,
    parameter int CHIP_CYC    = 60,
    parameter int PPROG_CYC   = 20,
    parameter int PERASE_CYC  = 80,
    parameter int PULSE_LIMIT = 100,
    parameter int FAIL_HOLD   = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    input  logic          prot_i,
    input  logic          force_timeout_i,
    input  logic          rd_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic          busy_o
);
    st_e        st;
    op_e        op_q;
    logic       launch;
    logic       commit;
    logic [7:0] arr_byte;
    logic       prog_msb;

    fsr_sequencer #(
        .PROG_CYC   (PROG_CYC),
        .SECT_CYC   (SECT_CYC),
        .CHIP_CYC   (CHIP_CYC),
        .PPROG_CYC  (PPROG_CYC),
        .PERASE_CYC (PERASE_CYC),
        .PULSE_LIMIT(PULSE_LIMIT),
        .FAIL_HOLD  (FAIL_HOLD)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_e'(op_i)),
        .prot_i  (prot_i),
        .force_i (force_timeout_i),
        .rd_i    (rd_i),
        .st_o    (st),
        .op_q_o  (op_q),
        .launch_o(launch),
        .commit_o(commit),
        .busy_o  (busy_o)
    );

    fsr_array #(
        .AW    (AW),
        .SECT_W(SECT_W)
    ) i_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .addr_i    (addr_i),
        .data_i    (data_i),
        .commit_i  (commit),
        .op_q_i    (op_q),
        .rd_addr_i (rd_addr_i),
        .rd_byte_o (arr_byte),
        .prog_msb_o(prog_msb)
    );

    fsr_status i_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_i      (st),
        .op_q_i    (op_q),
        .prog_msb_i(prog_msb),
        .launch_i  (launch),
        .rd_i      (rd_i),
        .arr_byte_i(arr_byte),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: tb/test_flash_status_responder.sv
module test_flash_status_responder;
    localparam int AW = 6, SECT_W = 2, DEPTH = 1 << AW;
    localparam int PC = 6, SC = 14, CC = 20, PP = 9, PE = 25, LIM = 32, HOLD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, prot_i = 0, force_timeout_i = 0, rd_i = 0;
    logic [1:0] op_i = 0;
    logic [AW-1:0] addr_i = 0, rd_addr_i = 0;
    logic [7:0] data_i = 0;
    logic [7:0] rd_data_o;
    logic busy_o;

    int cyc = 0, checks = 0, fails = 0;
    logic [7:0] sh [DEPTH];

    flash_status_responder #(
        .AW(AW), .SECT_W(SECT_W), .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC),
        .PPROG_CYC(PP), .PERASE_CYC(PE), .PULSE_LIMIT(LIM), .FAIL_HOLD(HOLD)
    ) i_flash_status_responder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .data_i(data_i), .prot_i(prot_i), .force_timeout_i(force_timeout_i),
        .rd_i(rd_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pattern(input int i);
        return 8'((i * 29 + 7) % 256);
    endfunction

    function automatic int run_len(input logic [1:0] op, input bit pr, input bit fo);
        if (fo) return LIM;
        if (pr) return (op == 2'b00) ? PP : PE;
        return (op == 2'b00) ? PC : (op == 2'b01) ? SC : CC;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic apply_op(input logic [1:0] op, input int a, input logic [7:0] d);
        logic [AW-1:0] av;
        av = AW'(a);
        for (int i = 0; i < DEPTH; i++) begin
            logic [AW-1:0] iv;
            iv = AW'(i);
            if (op == 2'b10) sh[i] = 8'hFF;
            else if (op == 2'b01 && iv[AW-1 -: SECT_W] == av[AW-1 -: SECT_W]) sh[i] = 8'hFF;
        end
        if (op == 2'b00) sh[a] = d;
    endtask

    task automatic do_read(input int a, output logic [7:0] got);
        rd_i = 1'b1;
        rd_addr_i = AW'(a);
        @(negedge clk);
        rd_i = 1'b0;
        got = rd_data_o;
    endtask

    task automatic idle_read(input int a, input string req);
        logic [7:0] got;
        do_read(a, got);
        chk(req, got, sh[a]);
    endtask

    task automatic run_op(input logic [1:0] op, input int a, input logic [7:0] d,
                          input bit pr, input bit fo, input int gapmax, input bit inject);
        int k, len, j, ra, nrd;
        bit tg, done, applied;
        logic poll;
        logic [7:0] exp, got;
        string tag;
        start_i = 1; op_i = op; addr_i = AW'(a); data_i = d; prot_i = pr; force_timeout_i = fo;
        k = cyc + 1;
        @(negedge clk);
        start_i = 0; data_i = 8'($urandom); op_i = 2'($urandom);
        prot_i = 1'($urandom); force_timeout_i = 1'($urandom);
        chk("R2 busy after start", {7'b0, busy_o}, 8'h01);
        len = run_len(op, pr, fo);
        poll = (op == 2'b00) ? ~d[7] : 1'b0;
        tg = 0; done = 0; applied = 0; nrd = 0;
        while (!done) begin
            repeat ($urandom_range(gapmax, 0)) @(negedge clk);
            ra = (nrd == 0) ? a : int'($urandom_range(DEPTH - 1, 0));
            j = cyc + 1 - k;
            do_read(ra, got);
            if (j <= len) begin
                exp = {poll, tg, 6'b0}; tg = ~tg;
                tag = fo ? "R10 R3 R4 R5 run" : pr ? "R8 R9 R4 R5 protected run" : "R3 R4 R5 R6 run";
                chk("R2 busy during run", {7'b0, busy_o}, 8'h01);
            end else if (fo) begin
                if (j <= len + HOLD) begin
                    exp = {poll, tg, 1'b1, 5'b0}; tg = ~tg; tag = "R10 hold";
                end else begin
                    exp = sh[ra]; done = 1; tag = "R10 back to read mode";
                end
            end else begin
                if (!applied && !pr) apply_op(op, a, d);
                applied = 1;
                exp = {sh[ra][7], tg, 6'b0}; done = 1; tag = "R7 completion read";
            end
            chk(tag, got, exp);
            if (inject && nrd == 0) begin
                start_i = 1; op_i = 2'b10; prot_i = 0; force_timeout_i = 0;
                @(negedge clk);
                start_i = 0;
            end
            nrd++;
        end
        chk("R2 busy low after return", {7'b0, busy_o}, 8'h00);
        idle_read(a, pr ? "R8 R9 target unchanged" : fo ? "R10 target unchanged" : "R6 target result");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] got, held;
        void'($urandom(32'd4711));
        for (int i = 0; i < DEPTH; i++) sh[i] = pattern(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset rd_data", rd_data_o, 8'h00);
        chk("R2 reset busy", {7'b0, busy_o}, 8'h00);
        idle_read(0, "R1 reset content");
        idle_read(DEPTH - 1, "R1 reset content");
        for (int i = 0; i < 6; i++) idle_read(int'($urandom_range(DEPTH - 1, 0)), "R1 idle read");

        // R11: data holds without a strobe
        do_read(5, held);
        repeat (4) @(negedge clk);
        chk("R11 hold", rd_data_o, held);

        // R2: code 11 is ignored
        start_i = 1; op_i = 2'b11; addr_i = 0; data_i = 8'h00;
        @(negedge clk);
        start_i = 0;
        chk("R2 op 11 ignored", {7'b0, busy_o}, 8'h00);
        idle_read(0, "R2 op 11 left array");

        // Directed: back-to-back reads to pin each boundary
        run_op(2'b00, 10, 8'h3C, 0, 0, 0, 0);
        run_op(2'b00, 11, 8'hA5, 0, 0, 0, 0);
        run_op(2'b01, 20, 8'h00, 0, 0, 0, 0);
        idle_read(16, "R6 sector erased");
        idle_read(31, "R6 sector erased");
        idle_read(32, "R6 other sector kept");
        run_op(2'b00, 40, 8'h81, 1, 0, 0, 0);
        run_op(2'b01, 50, 8'h00, 1, 0, 0, 0);
        idle_read(49, "R9 protected erase kept");
        run_op(2'b00, 3, 8'h11, 0, 1, 0, 0);
        run_op(2'b00, 7, 8'h55, 0, 0, 1, 1);
        idle_read(60, "R2 injected chip erase ignored");
        run_op(2'b10, 0, 8'h00, 0, 0, 1, 0);
        for (int i = 0; i < DEPTH; i += 9) idle_read(i, "R6 chip erased");

        // Random operations
        for (int n = 0; n < 40; n++) begin
            logic [1:0] op;
            op = 2'($urandom_range(2, 0));
            run_op(op, int'($urandom_range(DEPTH - 1, 0)), 8'($urandom),
                   ($urandom_range(3, 0) == 0), ($urandom_range(5, 0) == 0),
                   3, ($urandom_range(2, 0) == 0));
            idle_read(int'($urandom_range(DEPTH - 1, 0)), "R1 idle read after op");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule